// File: doc/BRIEF.md
# Register-Mapped I2C Target with Optional General Call

This block answers on a two-wire I2C bus as an addressed target and serves a small bank of byte registers. Both bus lines come in through synchronizers into the block clock domain, and the block never drives a line high. It only asserts pull-low enables, which the chip pads turn into open-drain outputs. The block finds START, repeated START and STOP on the bus. It shifts in the address byte and acknowledges when the 7-bit address matches its strap input. For a write, the first data byte sets an internal register index, and each later byte is stored at that index. For a read, bytes are returned from the index, which steps by one after every byte and wraps at the top of the bank.

The register index survives STOP and repeated START. A host can therefore set the index in a short write and fetch from it in a later read, whether that read follows a STOP or a repeated START. When a strap input is set, the block also accepts the all-zero broadcast address with a write bit and acts as a receiver for it. After each acknowledge slot the block holds the clock low until a ready input is high, which lets slow surrounding logic pace the bus.

Top module: `i2c_regslave`

## Requirements
- R1: SDA falling while SCL is high (START or repeated START) aborts any byte in progress and makes the next eight bits an address byte, sent MSB first, whose last bit is the direction (1 = target transmits).
- R2: SDA rising while SCL is high (STOP) returns the block to idle, and both pull-low outputs are released.
- R3: An address byte whose upper seven bits equal `dev_addr_i` is acknowledged by pulling SDA low for the ninth clock. Any other address is not acknowledged, and SDA stays released until the next START.
- R4: The byte 0x00 (address zero, write) is acknowledged and handled as a write only when `gc_en_i` is 1. When `gc_en_i` is 0 it is not acknowledged and the bytes that follow change nothing. Address zero with the read bit is never acknowledged.
- R5: In a write, the first data byte loads the register index from its low log2(DEPTH) bits, and each later byte is stored at the index and acknowledged.
- R6: In a read, each byte shifted out MSB first is the register at the current index.
- R7: The register index keeps its value across STOP and repeated START.
- R8: After any acknowledge slot, SCL is held low while `ready_i` is 0 and released once it is 1. SCL is never pulled low while `ready_i` has been 1 for the previous cycles.
- R9: The index steps by one after every byte stored or read, and wraps from DEPTH-1 to 0.
- R10: When the host does not acknowledge a byte the block sent, the block releases SDA and drives nothing until the next START.
- R11: The SDA pull-low is only ever asserted during a cycle that follows a low synchronized SCL.
- R12: After reset both pull-low outputs are released, the register index is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, several times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level from the pad |
| sda_i | input | 1 | Bus data line level from the pad |
| dev_addr_i | input | 7 | Target address strap |
| gc_en_i | input | 1 | Accept the broadcast write address when 1 |
| ready_i | input | 1 | Surrounding logic ready; 0 stretches SCL after an acknowledge |
| scl_pull_o | output | 1 | Pull SCL low when 1 |
| sda_pull_o | output | 1 | Pull SDA low when 1 |

## Verification
A wrong bit counter or a mis-tracked phase shows up within one byte, as a missing or misplaced acknowledge or a shifted read value. A lost or corrupted register index stays hidden until the next read, so each write is followed by reads at and across the wrap point, and after STOP and repeated START. Ignored traffic (foreign address, disabled broadcast, START in the middle of a byte) is followed by a read that proves the bank and the index did not move, while SDA is watched every cycle for any pull during those transfers. The stretch output is compared every cycle against the ready history, so a one-cycle false pull is caught at once.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   localparam int unsigned BYTE_BITS = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_HOLD,
      ST_TX,
      ST_TX_ACK
   } slv_state_t;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_PTR,
      PH_DATA
   } rx_phase_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
   parameter int unsigned     WIDTH   = 2,
   parameter int unsigned     STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("i2cs_sync: STAGES must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
   assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

   p_cond_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> !bus_start);
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] cells [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   cells[e] <= '0;
         else if (wr_en && wr_idx == IDX_W'(e))         cells[e] <= wr_data;
      end
   end

   assign rd_data = cells[rd_idx];
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
   import i2cs_pkg::*;
#(
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          GC_SUPPORT  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [6:0] dev_addr_i,
   input  logic       gc_en_i,
   input  logic       ready_i,
   output logic       scl_pull_o,
   output logic       sda_pull_o
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(BYTE_BITS + 2);
   localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_BITS);
   localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_BITS + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("i2c_regslave: DEPTH must be a power of two, at least 2");
   end

   logic [1:0] line_s;
   logic       scl_s, sda_s;
   logic       scl_rise, scl_fall, ev_start, ev_stop;

   i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(line_s));
   assign scl_s = line_s[1];
   assign sda_s = line_s[0];

   i2cs_bus_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(ev_start), .bus_stop(ev_stop));

   slv_state_t           state;
   rx_phase_t            phase;
   logic [CNT_W-1:0]     bitcnt;
   logic [BYTE_BITS-1:0] shreg;
   logic [PTR_W-1:0]     ptr;
   logic                 rw_q, mst_ack_q, sda_pull_q, scl_pull_q;
   logic                 wr_en, own_hit, gc_hit, byte_in;
   logic [BYTE_BITS-1:0] rd_data;

   assign own_hit = (shreg[7:1] == dev_addr_i);
   if (GC_SUPPORT) begin : g_gc
      assign gc_hit = gc_en_i && (shreg == '0);
   end else begin : g_no_gc
      assign gc_hit = 1'b0;
   end

   assign byte_in = (state == ST_RX) && scl_fall && (bitcnt == CNT_BYTE);
   assign wr_en   = byte_in && (phase == PH_DATA);

   i2cs_regfile #(.DEPTH(DEPTH), .DATA_W(BYTE_BITS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr), .wr_data(shreg),
      .rd_idx(ptr), .rd_data(rd_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         phase      <= PH_ADDR;
         bitcnt     <= '0;
         shreg      <= '0;
         ptr        <= '0;
         rw_q       <= 1'b0;
         mst_ack_q  <= 1'b0;
         sda_pull_q <= 1'b0;
         scl_pull_q <= 1'b0;
      end else if (ev_start) begin
         state      <= ST_RX;
         phase      <= PH_ADDR;
         bitcnt     <= '0;
         sda_pull_q <= 1'b0;
         scl_pull_q <= 1'b0;
      end else if (ev_stop) begin
         state      <= ST_IDLE;
         sda_pull_q <= 1'b0;
         scl_pull_q <= 1'b0;
      end else begin
         unique case (state)
            ST_RX: begin
               if (scl_rise) begin
                  shreg  <= {shreg[BYTE_BITS-2:0], sda_s};
                  bitcnt <= bitcnt + 1'b1;
               end else if (byte_in) begin
                  unique case (phase)
                     PH_ADDR: begin
                        if (own_hit || gc_hit) begin
                           rw_q       <= shreg[0];
                           phase      <= PH_PTR;
                           sda_pull_q <= 1'b1;
                           state      <= ST_RX_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end
                     PH_PTR: begin
                        ptr        <= shreg[PTR_W-1:0];
                        phase      <= PH_DATA;
                        sda_pull_q <= 1'b1;
                        state      <= ST_RX_ACK;
                     end
                     default: begin
                        ptr        <= ptr + 1'b1;
                        sda_pull_q <= 1'b1;
                        state      <= ST_RX_ACK;
                     end
                  endcase
               end
            end
            ST_RX_ACK: begin
               if (scl_rise) begin
                  bitcnt <= CNT_ACK;
               end else if (scl_fall && bitcnt == CNT_ACK) begin
                  sda_pull_q <= 1'b0;
                  scl_pull_q <= ~ready_i;
                  state      <= ST_HOLD;
               end
            end
            ST_HOLD: begin
               if (ready_i) begin
                  scl_pull_q <= 1'b0;
                  bitcnt     <= '0;
                  if (rw_q) begin
                     shreg      <= rd_data;
                     ptr        <= ptr + 1'b1;
                     sda_pull_q <= ~rd_data[BYTE_BITS-1];
                     state      <= ST_TX;
                  end else begin
                     state <= ST_RX;
                  end
               end else begin
                  scl_pull_q <= 1'b1;
               end
            end
            ST_TX: begin
               if (scl_rise) begin
                  bitcnt <= bitcnt + 1'b1;
               end else if (scl_fall) begin
                  if (bitcnt == CNT_BYTE) begin
                     sda_pull_q <= 1'b0;
                     state      <= ST_TX_ACK;
                  end else begin
                     shreg      <= {shreg[BYTE_BITS-2:0], 1'b0};
                     sda_pull_q <= ~shreg[BYTE_BITS-2];
                  end
               end
            end
            ST_TX_ACK: begin
               if (scl_rise) begin
                  bitcnt    <= CNT_ACK;
                  mst_ack_q <= ~sda_s;
               end else if (scl_fall && bitcnt == CNT_ACK) begin
                  if (mst_ack_q) begin
                     scl_pull_q <= ~ready_i;
                     state      <= ST_HOLD;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign scl_pull_o = scl_pull_q;
   assign sda_pull_o = sda_pull_q;

   p_start_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start |=> (state == ST_RX && phase == PH_ADDR && bitcnt == '0));
   p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> (state == ST_IDLE && !sda_pull_o && !scl_pull_o));
   p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RX_ACK) |-> sda_pull_o);
   p_stretch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scl_pull_o |-> (state == ST_HOLD));
   p_stretch_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && ready_i && !ev_start && !ev_stop) |=> !scl_pull_o);
   p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ptr == PTR_W'($past(ptr) + 1'b1)));
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_pull_o);
   p_sda_low_scl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> !$past(scl_s));
endmodule

// File: tb/tb_i2c_regslave.sv
module tb_i2c_regslave;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0;
   logic m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic ready = 1'b1, ready_prev = 1'b1;
   logic gc_en = 1'b0;
   logic quiet = 1'b0;
   logic scl_pull, sda_pull, scl_line, sda_line;
   localparam logic [6:0] MY_ADDR = 7'h5A;

   assign scl_line = ~(m_scl_low | scl_pull);
   assign sda_line = ~(m_sda_low | sda_pull);

   i2c_regslave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .dev_addr_i(MY_ADDR), .gc_en_i(gc_en), .ready_i(ready),
      .scl_pull_o(scl_pull), .sda_pull_o(sda_pull));

   int vec = 0, bad = 0;
   logic [7:0] mem [16];
   int mptr = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) ready_prev <= ready;

   // per-clock reference comparisons
   always @(negedge clk) begin
      if (rst_n) begin
         if (quiet) chk(sda_pull == 1'b0, "R3/R4 quiet SDA", sda_pull, 0);
         if (ready && ready_prev) chk(scl_pull == 1'b0, "R8 no stretch", scl_pull, 0);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic m_clk(output bit r);
      m_scl_low = 1'b0;
      do tick(1); while (!scl_line);
      tick(5);
      r = sda_line;
      tick(5);
      m_scl_low = 1'b1;
      tick(10);
   endtask

   task automatic m_start();
      m_sda_low = 1'b0; tick(10);
      m_scl_low = 1'b0;
      do tick(1); while (!scl_line);
      tick(10);
      m_sda_low = 1'b1; tick(10);
      m_scl_low = 1'b1; tick(10);
   endtask

   task automatic m_stop();
      m_sda_low = 1'b1; tick(10);
      m_scl_low = 1'b0;
      do tick(1); while (!scl_line);
      tick(10);
      m_sda_low = 1'b0; tick(10);
   endtask

   task automatic m_wbyte(input logic [7:0] b, output bit ack);
      bit r;
      for (int i = 7; i >= 0; i--) begin
         m_sda_low = ~b[i]; tick(3);
         m_clk(r);
      end
      m_sda_low = 1'b0; tick(3);
      m_clk(r);
      ack = ~r;
   endtask

   task automatic m_rbyte(input bit give_ack, output logic [7:0] b);
      bit r;
      m_sda_low = 1'b0;
      for (int i = 0; i < 8; i++) begin
         tick(3);
         m_clk(r);
         b = {b[6:0], r};
      end
      m_sda_low = give_ack; tick(3);
      m_clk(r);
      m_sda_low = 1'b0;
   endtask

   task automatic read_n(input int n);
      logic [7:0] b;
      for (int i = 0; i < n; i++) begin
         m_rbyte(i != n - 1, b);
         chk(b == mem[mptr], "R6/R9 read data", b, mem[mptr]);
         mptr = (mptr + 1) % 16;
      end
   endtask

   // write: address, index byte, then n data bytes
   task automatic wr3(input logic [7:0] p, input int n, input logic [7:0] d0, d1, d2);
      bit ack;
      logic [7:0] d [3];
      d[0] = d0; d[1] = d1; d[2] = d2;
      m_start();
      m_wbyte({MY_ADDR, 1'b0}, ack); chk(ack, "R3 address ack", ack, 1);
      m_wbyte(p, ack);               chk(ack, "R5 index ack", ack, 1);
      mptr = p % 16;
      for (int i = 0; i < n; i++) begin
         m_wbyte(d[i], ack);         chk(ack, "R5 data ack", ack, 1);
         mem[mptr] = d[i];
         mptr = (mptr + 1) % 16;
      end
      m_stop();
   endtask

   task automatic rd_cur(input int n);
      bit ack;
      m_start();
      m_wbyte({MY_ADDR, 1'b1}, ack); chk(ack, "R7 read address ack", ack, 1);
      read_n(n);
      m_stop();
   endtask

   task automatic rd_at(input logic [7:0] p, input int n);
      bit ack;
      m_start();
      m_wbyte({MY_ADDR, 1'b0}, ack); chk(ack, "R3 address ack", ack, 1);
      m_wbyte(p, ack);               chk(ack, "R5 index ack", ack, 1);
      mptr = p % 16;
      m_start();
      m_wbyte({MY_ADDR, 1'b1}, ack); chk(ack, "R1 address after Sr", ack, 1);
      read_n(n);
      m_stop();
   endtask

   task automatic ignored_write(input logic [7:0] abyte, input string req);
      bit ack;
      quiet = 1'b1;
      m_start();
      m_wbyte(abyte, ack); chk(!ack, req, ack, 0);
      m_wbyte(8'h07, ack);
      m_wbyte(8'hEE, ack);
      m_stop();
      quiet = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      bit ack, r;
      for (int i = 0; i < 16; i++) mem[i] = 8'h00;
      tick(5);
      rst_n = 1'b1;
      tick(5);
      // R12 reset state
      chk(sda_pull == 1'b0, "R12 reset sda", sda_pull, 0);
      chk(scl_pull == 1'b0, "R12 reset scl", scl_pull, 0);
      rd_cur(2);                          // R12 index 0, registers zero

      wr3(8'h03, 3, 8'hA1, 8'hB2, 8'hC3); // R5
      rd_at(8'h03, 3);                    // R6 via repeated START
      wr3(8'hF5, 0, 8'h00, 8'h00, 8'h00); // R5 upper index bits ignored, index 5
      wr3(8'h0E, 3, 8'h11, 8'h22, 8'h33); // R9 write wrap 14,15,0
      wr3(8'h0E, 0, 8'h00, 8'h00, 8'h00); // set index only
      rd_cur(4);                          // R7 index survives STOP, R9 read wrap

      ignored_write({7'h22, 1'b0}, "R3 foreign address nack");
      rd_cur(2);                          // R3 nothing changed

      gc_en = 1'b0;
      ignored_write(8'h00, "R4 broadcast disabled nack");
      rd_cur(1);                          // R4 nothing changed
      gc_en = 1'b1;
      ignored_write(8'h01, "R4 broadcast read nack");
      m_start();
      m_wbyte(8'h00, ack); chk(ack, "R4 broadcast ack", ack, 1);
      m_wbyte(8'h09, ack); chk(ack, "R4 broadcast index ack", ack, 1);
      m_wbyte(8'h5C, ack); chk(ack, "R4 broadcast data ack", ack, 1);
      m_stop();
      mem[9] = 8'h5C; mptr = 10;
      rd_at(8'h09, 1);

      // R10: after host NACK, SDA stays released until next START
      rd_at(8'h0F, 2);
      tick(15);
      chk(sda_pull == 1'b0, "R10 released after nack", sda_pull, 0);

      // R1: START in the middle of a byte restarts address phase
      mptr = 2;
      wr3(8'h02, 0, 8'h00, 8'h00, 8'h00);
      m_start();
      m_wbyte({MY_ADDR, 1'b0}, ack); chk(ack, "R1 address ack", ack, 1);
      for (int i = 0; i < 4; i++) begin
         m_sda_low = i[0]; tick(3); m_clk(r);
      end
      m_start();
      m_wbyte({MY_ADDR, 1'b1}, ack); chk(ack, "R1 address after mid-byte START", ack, 1);
      read_n(2);
      m_stop();

      // R8: stretch while ready is low
      ready = 1'b0;
      fork
         rd_at(8'h03, 2);
         begin
            while (!scl_pull) tick(1);
            tick(60);
            chk(scl_pull == 1'b1, "R8 stretch held", scl_pull, 1);
            chk(scl_line == 1'b0, "R8 SCL low", scl_line, 0);
            ready = 1'b1;
         end
      join
      wr3(8'h0C, 2, 8'h9D, 8'h4E, 8'h00);
      rd_at(8'h0C, 2);

      tick(20);
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end
endmodule